// File: doc/BRIEF.md
# Device ROM header checker

This block validates the fixed header at the start of a device ROM image. The image arrives one byte per accepted beat on a valid/ready stream, starting at image offset 0. While the bytes stream past, the block captures the 64-bit unique ID. It runs an 8-bit CRC over the ID bytes and a 32-bit CRC over the data region. It also reads the length field and the revision byte.

The length field sits at bytes 14 and 15, which lie inside the region the 32-bit CRC covers. Once the length is known, the block counts the image down to its last byte. In the cycle after that byte is accepted, it presents a one-cycle result. The result carries a pass flag, a two-bit reason code, a revision warning, the unique ID and the total image size. If the length field declares an image shorter than the fixed header, the block gives up after byte 15. It reports at once and expects the next image to begin with the following byte. The block never reads the storage device itself, and it never interprets the entries that follow the header.

Top module: `drom_hdr_check`

## Requirements
- R1: After reset, `inReady` is 1 and `resValid` is 0, and the next accepted byte is taken as image offset 0.
- R2: `resValid` is high for exactly one cycle: the cycle right after the image's final byte is accepted. `inReady` is 0 in that cycle and 1 again in the next cycle. Each image yields exactly one result.
- R3: `uniqueId` holds image bytes 1 to 8, little-endian: byte 1 goes to bits 7:0 and byte 8 goes to bits 63:56.
- R4: An 8-bit CRC is computed over bytes 1 to 8 and compared with byte 0. It uses polynomial 0x07 and start value 0xFF, feeds each byte MSB first, and applies no output inversion. A mismatch gives reason code 2.
- R5: A 32-bit CRC is computed over bytes 13 up to the end of the image. It is the reflected Castagnoli CRC (polynomial 0x82F63B78, LSB first) with start value 0xFFFFFFFF and an inverted result. It is compared with the little-endian word in bytes 9 to 12. A mismatch gives reason code 3.
- R6: The length field is the low 10 bits of the little-endian word in bytes 14 to 15; the upper 6 bits of byte 15 are ignored. The image size is the length field plus 13. The size is reported on `imageSize`, and the image ends after exactly that many bytes.
- R7: If the image size is below 22, the reason code is 1. The result follows the acceptance of byte 15, and no further byte belongs to that image.
- R8: Reason codes rank 1 over 2 over 3. Code 0 means pass, and `resPass` is 1 exactly when the code is 0.
- R9: `revWarn` is 1 when byte 13 is greater than 1. It never changes the reason code.
- R10: Cycles with `inValid` low consume nothing and do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Image byte offered |
| inData | input | 8 | Image byte |
| inReady | output | 1 | Byte accepted when high with inValid |
| resValid | output | 1 | One-cycle result strobe |
| resPass | output | 1 | Header accepted |
| resCode | output | 2 | Reason: 0 pass, 1 too short, 2 ID CRC bad, 3 data CRC bad |
| revWarn | output | 1 | Revision byte above 1 |
| uniqueId | output | 64 | Captured unique ID |
| imageSize | output | 11 | Length field plus 13 |

## Verification
Both CRC comparisons resolve in the same report cycle. One image is built with a corrupted ID check byte and a corrupted data check word, and the bench expects code 2, so the priority is judged directly. A short image with a bad ID CRC also sets the size failure and the ID failure together, and it must report code 1. In a further image the revision warning falls on a passing result, and that image must still read code 0 with the warning raised.

// File: rtl/drom_hdr_pkg.sv
package drom_hdr_pkg;

  // fixed byte layout of the header
  localparam int CRC8_IDX  = 0;
  localparam int ID_FIRST  = 1;
  localparam int ID_BYTES  = 8;
  localparam int DCRC_IDX  = 9;
  localparam int DCRC_BYTES = 4;
  localparam int REV_IDX   = 13;
  localparam int LEN_IDX   = 14;

  localparam logic [7:0]  CRC8_POLY  = 8'h07;
  localparam logic [7:0]  CRC8_INIT  = 8'hFF;
  localparam logic [31:0] CRC32_POLY = 32'h82F63B78;
  localparam logic [31:0] CRC32_INIT = 32'hFFFF_FFFF;

  typedef struct packed {
    logic take;   // byte accepted this cycle
    logic clear;  // restart for the next image
  } ctrlStrobeT;

  typedef struct packed {
    logic shortHit; // current byte ends a too-short image
    logic lastHit;  // current byte is the image's final byte
  } dpStatusT;

  typedef enum logic [1:0] {
    RC_PASS  = 2'd0,
    RC_SHORT = 2'd1,
    RC_IDCRC = 2'd2,
    RC_DATA  = 2'd3
  } reasonT;

  function automatic logic [7:0] crc8Step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? CRC8_POLY : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [31:0] crc32Step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {1'b0, r[31:1]} ^ (fb ? CRC32_POLY : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/drom_hdr_ctrl.sv
module drom_hdr_ctrl
  import drom_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  dpStatusT   status,
  output ctrlStrobeT strobe,
  output logic       inReady,
  output logic       resValid
);

  typedef enum logic {ST_RUN, ST_REPORT} stateT;
  stateT state, stateNext;

  assign inReady      = (state == ST_RUN);
  assign resValid     = (state == ST_REPORT);
  assign strobe.take  = inValid && inReady;
  assign strobe.clear = (state == ST_REPORT);

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:    if (strobe.take && (status.shortHit || status.lastHit)) stateNext = ST_REPORT;
      ST_REPORT: stateNext = ST_RUN;
      default:   stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/drom_hdr_dp.sv
module drom_hdr_dp
  import drom_hdr_pkg::*;
#(
  parameter int LEN_BITS   = 10,
  parameter int DATA_START = 13,
  parameter int HDR_LEN    = 22,
  parameter int MAX_REV    = 1,
  parameter int SIZE_W     = 11
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [7:0]        inData,
  output dpStatusT          status,
  output logic [1:0]        resCode,
  output logic              revWarn,
  output logic [63:0]       uniqueId,
  output logic [SIZE_W-1:0] imageSize
);

  localparam int LEN_HI = LEN_BITS - 8;

  logic [SIZE_W-1:0] byteIdx;
  logic [7:0]        crc8Reg, expId, revReg, lenLo;
  logic [31:0]       crc32Reg, expData;
  logic [63:0]       idReg;
  logic [SIZE_W-1:0] sizeReg;
  logic              shortReg;

  logic [SIZE_W-1:0] sizeNow;
  logic              atLenHi;
  logic [ID_BYTES-1:0]   idHit;
  logic [DCRC_BYTES-1:0] dcrcHit;
  logic              inIdRange, inDataRange;

  assign sizeNow = SIZE_W'({inData[LEN_HI-1:0], lenLo}) + SIZE_W'(DATA_START);
  assign atLenHi = (byteIdx == SIZE_W'(LEN_IDX + 1));

  assign status.shortHit = atLenHi && (sizeNow < SIZE_W'(HDR_LEN));
  assign status.lastHit  = (byteIdx > SIZE_W'(LEN_IDX + 1)) && (byteIdx == sizeReg - SIZE_W'(1));

  genvar k;
  generate
    for (k = 0; k < ID_BYTES; k++) begin : g_idHit
      assign idHit[k] = strobe.take && (byteIdx == SIZE_W'(ID_FIRST + k));
    end
    for (k = 0; k < DCRC_BYTES; k++) begin : g_dcrcHit
      assign dcrcHit[k] = strobe.take && (byteIdx == SIZE_W'(DCRC_IDX + k));
    end
  endgenerate

  assign inIdRange   = |idHit;
  assign inDataRange = strobe.take && (byteIdx >= SIZE_W'(DATA_START));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      byteIdx  <= '0;
      crc8Reg  <= CRC8_INIT;
      crc32Reg <= CRC32_INIT;
      shortReg <= 1'b0;
    end else begin
      if (strobe.take) byteIdx <= byteIdx + SIZE_W'(1);
      if (inIdRange)   crc8Reg <= crc8Step(crc8Reg, inData);
      if (inDataRange) crc32Reg <= crc32Step(crc32Reg, inData);
      if (strobe.take && atLenHi) shortReg <= (sizeNow < SIZE_W'(HDR_LEN));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expId   <= '0;
      expData <= '0;
      idReg   <= '0;
      revReg  <= '0;
      lenLo   <= '0;
      sizeReg <= '0;
    end else begin
      if (strobe.take && byteIdx == SIZE_W'(CRC8_IDX)) expId  <= inData;
      if (strobe.take && byteIdx == SIZE_W'(REV_IDX))  revReg <= inData;
      if (strobe.take && byteIdx == SIZE_W'(LEN_IDX))  lenLo  <= inData;
      if (strobe.take && atLenHi)                      sizeReg <= sizeNow;
      for (int i = 0; i < ID_BYTES; i++)
        if (idHit[i]) idReg[8*i +: 8] <= inData;
      for (int i = 0; i < DCRC_BYTES; i++)
        if (dcrcHit[i]) expData[8*i +: 8] <= inData;
    end
  end

  logic idBad, dataBad;
  assign idBad   = (crc8Reg != expId);
  assign dataBad = (~crc32Reg != expData);

  always_comb begin
    if (shortReg)     resCode = RC_SHORT;
    else if (idBad)   resCode = RC_IDCRC;
    else if (dataBad) resCode = RC_DATA;
    else              resCode = RC_PASS;
  end

  assign revWarn   = (revReg > 8'(MAX_REV));
  assign uniqueId  = idReg;
  assign imageSize = sizeReg;

endmodule

// File: rtl/drom_hdr_check.sv
module drom_hdr_check
  import drom_hdr_pkg::*;
#(
  parameter int LEN_BITS   = 10,
  parameter int DATA_START = 13,
  parameter int HDR_LEN    = 22,
  parameter int MAX_REV    = 1,
  localparam int SIZE_W    = $clog2((1 << LEN_BITS) + DATA_START + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  output logic              resValid,
  output logic              resPass,
  output logic [1:0]        resCode,
  output logic              revWarn,
  output logic [63:0]       uniqueId,
  output logic [SIZE_W-1:0] imageSize
);

  ctrlStrobeT strobe;
  dpStatusT   status;

  drom_hdr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .status   (status),
    .strobe   (strobe),
    .inReady  (inReady),
    .resValid (resValid)
  );

  drom_hdr_dp #(
    .LEN_BITS   (LEN_BITS),
    .DATA_START (DATA_START),
    .HDR_LEN    (HDR_LEN),
    .MAX_REV    (MAX_REV),
    .SIZE_W     (SIZE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .status    (status),
    .resCode   (resCode),
    .revWarn   (revWarn),
    .uniqueId  (uniqueId),
    .imageSize (imageSize)
  );

  assign resPass = (resCode == RC_PASS);

endmodule

// File: rtl/drom_hdr_chk.sv
module drom_hdr_chk #(
  parameter int SIZE_W  = 11,
  parameter int HDR_LEN = 22
)(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              resValid,
  input logic              resPass,
  input logic [1:0]        resCode,
  input logic [SIZE_W-1:0] imageSize
);

  // R2
  report_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !inReady);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R2
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> inReady);

  // R2
  after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(inValid && inReady));

  // R8
  pass_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resPass == (resCode == 2'd0)));

  // R7
  short_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && imageSize < SIZE_W'(HDR_LEN)) |-> (resCode == 2'd1));

  // R7
  short_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCode == 2'd1) |-> (imageSize < SIZE_W'(HDR_LEN)));

endmodule

bind drom_hdr_check drom_hdr_chk #(.SIZE_W(SIZE_W), .HDR_LEN(HDR_LEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .resValid  (resValid),
  .resPass   (resPass),
  .resCode   (resCode),
  .imageSize (imageSize)
);

// File: tb/drom_hdr_check_tb.sv
module drom_hdr_check_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, inValid;
  logic [7:0]  inData;
  logic        inReady, resValid, resPass, revWarn;
  logic [1:0]  resCode;
  logic [63:0] uniqueId;
  logic [10:0] imageSize;

  drom_hdr_check u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .resValid(resValid), .resPass(resPass),
    .resCode(resCode), .revWarn(revWarn), .uniqueId(uniqueId),
    .imageSize(imageSize)
  );

  typedef struct packed {
    logic [1:0]  code;
    logic        warn;
    logic [63:0] id;
    logic [10:0] size;
  } expT;

  expT   expQ[$];
  string tagQ[$];
  int total = 0, bad = 0;
  int cyc = 0, lastCyc = -1, resCount = 0, sentCount = 0;
  bit gapMode = 0, seenRes = 0;
  logic [7:0] img [0:1100];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] refCrc8();
    logic [7:0] v = 8'hFF;
    for (int i = 1; i <= 8; i++) begin
      v ^= img[i];
      for (int j = 0; j < 8; j++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    end
    return v;
  endfunction

  function automatic logic [31:0] refCrc32(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 13; i < n; i++) begin
      c ^= {24'h0, img[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input logic [63:0] id, input logic [7:0] rev, input int len,
                       input logic [5:0] hiBits, input logic [7:0] seed,
                       input bit badId, input bit badData);
    int n;
    logic [31:0] c;
    n = len + 13;
    for (int i = 0; i < 8; i++) img[1+i] = id[8*i +: 8];
    img[13] = rev;
    img[14] = len[7:0];
    img[15] = {hiBits, len[9:8]};
    for (int i = 16; i < n; i++) img[i] = seed + 8'(i * 7);
    img[0] = refCrc8() ^ (badId ? 8'h5A : 8'h00);
    c = refCrc32(n) ^ (badData ? 32'h1 : 32'h0);
    for (int i = 0; i < 4; i++) img[9+i] = c[8*i +: 8];
  endtask

  task automatic sendImage(input string tag);
    expT e;
    int size, cnt;
    logic [63:0] id;
    size = int'({img[15][1:0], img[14]}) + 13;
    for (int i = 0; i < 8; i++) id[8*i +: 8] = img[1+i];
    e.id = id;
    e.size = 11'(size);
    e.warn = (img[13] > 8'd1);
    if (size < 22) begin
      e.code = 2'd1; cnt = 16;
    end else begin
      cnt = size;
      if (refCrc8() != img[0]) e.code = 2'd2;
      else if (refCrc32(size) != {img[12], img[11], img[10], img[9]}) e.code = 2'd3;
      else e.code = 2'd0;
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    sentCount++;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      if (gapMode && (i % 3 == 1)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inData  = img[i];
      while (!inReady) @(negedge clk);
      @(posedge clk);
      #1;
    end
    lastCyc = cyc;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        expT e;
        string t;
        resCount++;
        chk("R2", 64'(inReady), 64'd0, "inReady during result");
        chk("R2", 64'(cyc), 64'(lastCyc), "result cycle");
        if (expQ.size() == 0) begin
          chk("R2", 64'd1, 64'd0, "unexpected result");
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(t,    64'(resCode), 64'(e.code), "reason code");
          chk("R8", 64'(resPass), 64'(e.code == 2'd0), "pass flag");
          chk("R9", 64'(revWarn), 64'(e.warn), "revision warning");
          chk("R3", uniqueId, e.id, "unique id");
          chk("R6", 64'(imageSize), 64'(e.size), "image size");
        end
        seenRes = 1'b1;
      end else if (seenRes) begin
        chk("R2", 64'(inReady), 64'd1, "inReady after result");
        seenRes = 1'b0;
      end
    end
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inData = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 64'(inReady), 64'd1, "inReady after reset");
    chk("R1", 64'(resValid), 64'd0, "resValid after reset");

    // R6 minimum passing size 22, R4/R5 pass
    build(64'h0123_4567_89AB_CDEF, 8'd0, 9, 6'h00, 8'h11, 0, 0);
    sendImage("R6");
    // R6 upper bits of byte 15 ignored, revision 1 no warning
    build(64'hFEDC_BA98_7654_3210, 8'd1, 40, 6'h2B, 8'h3C, 0, 0);
    sendImage("R6");
    // R4 ID CRC mismatch
    build(64'h1111_2222_3333_4444, 8'd0, 30, 6'h00, 8'h05, 1, 0);
    sendImage("R4");
    // R5 data CRC mismatch
    build(64'hA5A5_5A5A_0F0F_F0F0, 8'd0, 25, 6'h00, 8'h77, 0, 1);
    sendImage("R5");
    // R8 both CRCs bad in one report cycle
    build(64'h0000_0000_0000_0001, 8'd0, 12, 6'h00, 8'h99, 1, 1);
    sendImage("R8");
    // R7 short image, then a good image straight after byte 15
    build(64'hDEAD_BEEF_CAFE_F00D, 8'd0, 8, 6'h00, 8'h00, 0, 0);
    sendImage("R7");
    build(64'h1357_9BDF_2468_ACE0, 8'd0, 20, 6'h00, 8'h42, 0, 0);
    sendImage("R7");
    // R7 short image with bad ID CRC still reports code 1
    build(64'h0F1E_2D3C_4B5A_6978, 8'd0, 0, 6'h3F, 8'h00, 1, 0);
    sendImage("R7");
    // R9 revision above 1 on a passing image
    build(64'h8899_AABB_CCDD_EEFF, 8'd5, 17, 6'h00, 8'h21, 0, 0);
    sendImage("R9");
    // R10 idle gaps inside the stream
    gapMode = 1;
    build(64'h7766_5544_3322_1100, 8'd2, 33, 6'h15, 8'hC3, 0, 0);
    sendImage("R10");
    build(64'h0102_0304_0506_0708, 8'd0, 28, 6'h00, 8'h08, 0, 1);
    sendImage("R10");
    gapMode = 0;
    // R5 longer data region
    build(64'hCAFE_0000_BEEF_0000, 8'd1, 300, 6'h01, 8'h6D, 0, 0);
    sendImage("R5");

    repeat (5) @(negedge clk);
    chk("R2", 64'(resCount), 64'(sentCount), "one result per image");
    chk("R2", 64'(expQ.size()), 64'd0, "pending expectations");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule